// File: doc/BRIEF.md
# Class-Arbitrated Framed Packet Transmit Source

This block sits on the user side of a packet link transmitter. Upstream logic queues packet descriptors: a traffic class, a length in 32-bit words and a tag. The block keeps them in one FIFO per class: non-posted, posted and completion. It streams each packet out over a 64-bit framed port with active-low handshakes. The payload is fetched through a side port. The block names the class, tag and beat it needs, and upstream returns the matching 64-bit word in the same cycle.

A packet is only launched when its class queue is non-empty and the receiver reports buffer room for that class on a 4-bit availability vector. Bit 3 of that vector tells whether a completion can be accepted without risk of stalling. When it is low, posted and non-posted traffic go before completions. The class decision is taken once, at packet start. A started packet is discontinued on request once its first beat has been accepted. Discontinued packets are dropped and counted.

Top module: `tlp_tx_src`

## Requirements
- R1: While rst_ni is low and after reset, src_rdy_n_o, sof_n_o, eof_n_o and src_dsc_n_o are 1 and drop_cnt_o is 0.
- R2: A beat is accepted only on a clock edge where src_rdy_n_o and dst_rdy_n_i are both 0 and src_dsc_n_o is 1. While dst_rdy_n_i is 1, the beat index, data, framing and remainder hold.
- R3: A packet of L words (1 to MAX_DW) is sent as ceil(L/2) beats. sof_n_o is 0 on beat 0 only and eof_n_o is 0 on the last beat only, and both are asserted only together with src_rdy_n_o.
- R4: On the last beat rem_n_o is 8'h00 for even L (64 bits valid) and 8'h0F for odd L (bits 63:32 valid); on other beats it is 8'h00.
- R5: A class is launched only if its queue holds a descriptor and its buf_av_i bit is 1 (bit 0 non-posted, bit 1 posted, bit 2 completion). With no eligible class, src_rdy_n_o stays 1.
- R6: With buf_av_i[3]=0 the launch priority is posted, then non-posted, then completion. With buf_av_i[3]=1 it is completion, then posted, then non-posted.
- R7: If a class is eligible at the edge that ends a packet (last beat accepted or discontinue), the next packet's sof beat is presented in the very next cycle.
- R8: The class, length and tag of a packet are fixed at launch. Later changes of buf_av_i do not stop or alter a packet in flight.
- R9: With a packet in flight whose first beat has been accepted, abort_i=1 drives src_dsc_n_o to 0 in the same cycle. That ends the packet without resending it and increments drop_cnt_o (wrapping) by one. abort_i is ignored when idle or on the first beat.
- R10: Each class queue is first-in first-out with Q_DEPTH entries (push_cls_i 0 non-posted, 1 posted, 2 completion). A push into a full queue, or with push_cls_i=3, is ignored.
- R11: pl_cls_o, pl_tag_o and pl_beat_o identify the beat being presented, and td_o carries pl_data_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Queue a descriptor |
| push_cls_i | input | 2 | Class of pushed descriptor (0 NP, 1 P, 2 CPL) |
| push_len_i | input | LEN_W | Packet length in 32-bit words |
| push_tag_i | input | TAG_W | Packet tag |
| buf_av_i | input | 4 | Receiver buffer room per class, bit 3 completion look-ahead |
| abort_i | input | 1 | Request discontinue of the packet in flight |
| dst_rdy_n_i | input | 1 | Receiver ready, active low |
| td_o | output | 64 | Beat data |
| sof_n_o | output | 1 | Start of frame, active low |
| eof_n_o | output | 1 | End of frame, active low |
| src_rdy_n_o | output | 1 | Source ready, active low |
| src_dsc_n_o | output | 1 | Discontinue, active low |
| rem_n_o | output | 8 | Remainder on last beat, active low |
| pl_cls_o | output | 2 | Payload fetch: class |
| pl_tag_o | output | TAG_W | Payload fetch: tag |
| pl_beat_o | output | BEAT_W | Payload fetch: beat index |
| pl_data_i | input | 64 | Payload word for the fetch request |
| drop_cnt_o | output | DROP_W | Count of discontinued packets |

## Verification
A wrong beat counter shows at once as a payload word for the wrong beat on td_o and as misplaced sof/eof, in the very cycle it drifts. A queue pointer or count error shows up at the next launch of that class as a wrong tag or length. An unexpected launch while the bench expects idle also exposes it. Priority or eligibility faults show as the wrong pl_cls_o on the first cycle of a packet. A discontinue fault shows within the same cycle on src_dsc_n_o and one cycle later on drop_cnt_o.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;
  localparam int N_CLS = 3;

  typedef enum logic [1:0] {
    CLS_NP  = 2'd0,
    CLS_P   = 2'd1,
    CLS_CPL = 2'd2
  } tx_cls_e;

  localparam logic [7:0] REM_FULL = 8'h00;
  localparam logic [7:0] REM_HIGH = 8'h0F;
endpackage

// File: rtl/tlp_tx_desc_fifo.sv
module tlp_tx_desc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         nonempty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  // full check uses the registered count, so a pop does not make room in the same cycle
  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o     = mem_q[rd_q];
  assign nonempty_o = (cnt_q != '0);
endmodule

// File: rtl/tlp_tx_pick.sv
module tlp_tx_pick
  import tlp_tx_pkg::*;
(
  input  logic [N_CLS-1:0] elig_i,
  input  logic             cpl_safe_i,
  output logic             valid_o,
  output logic [1:0]       cls_o
);
  always_comb begin
    valid_o = |elig_i;
    cls_o   = CLS_NP;
    if (cpl_safe_i) begin
      if      (elig_i[CLS_CPL]) cls_o = CLS_CPL;
      else if (elig_i[CLS_P])   cls_o = CLS_P;
      else                      cls_o = CLS_NP;
    end else begin
      // completion last: it may block the link when its look-ahead room is absent
      if      (elig_i[CLS_P])   cls_o = CLS_P;
      else if (elig_i[CLS_NP])  cls_o = CLS_NP;
      else                      cls_o = CLS_CPL;
    end
  end
endmodule

// File: rtl/tlp_tx_framer.sv
module tlp_tx_framer
  import tlp_tx_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int BEAT_W = 4,
  parameter int TAG_W  = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pick_valid_i,
  input  logic [1:0]        pick_cls_i,
  input  logic [LEN_W-1:0]  head_len_i,
  input  logic [TAG_W-1:0]  head_tag_i,
  input  logic              abort_i,
  input  logic              dst_rdy_n_i,
  output logic              launch_o,
  output logic              busy_o,
  output logic              sof_n_o,
  output logic              eof_n_o,
  output logic              dsc_n_o,
  output logic [7:0]        rem_n_o,
  output logic [1:0]        cls_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              busy_q;
  logic [1:0]        cls_q;
  logic [LEN_W-1:0]  len_q;
  logic [TAG_W-1:0]  tag_q;
  logic [BEAT_W-1:0] beat_q;
  logic [DROP_W-1:0] drop_q;
  logic first_beat, last_beat, dsc, xfer, done;

  always_comb begin
    first_beat = (beat_q == '0);
    // beat b covers words 2b and 2b+1
    last_beat  = ((LEN_W'(beat_q) << 1) + LEN_W'(2)) >= len_q;
    dsc        = busy_q && abort_i && !first_beat;
    xfer       = busy_q && !dst_rdy_n_i && !dsc;
    done       = dsc || (xfer && last_beat);
    launch_o   = pick_valid_i && (!busy_q || done);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cls_q  <= CLS_NP;
      len_q  <= '0;
      tag_q  <= '0;
      beat_q <= '0;
      drop_q <= '0;
    end else begin
      if (launch_o) begin
        busy_q <= 1'b1;
        cls_q  <= pick_cls_i;
        len_q  <= head_len_i;
        tag_q  <= head_tag_i;
        beat_q <= '0;
      end else if (done) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else if (xfer) begin
        beat_q <= beat_q + 1'b1;
      end
      if (dsc) drop_q <= drop_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign sof_n_o    = !(busy_q && first_beat);
  assign eof_n_o    = !(busy_q && last_beat);
  assign dsc_n_o    = !dsc;
  assign rem_n_o    = (busy_q && last_beat && len_q[0]) ? REM_HIGH : REM_FULL;
  assign cls_o      = cls_q;
  assign tag_o      = tag_q;
  assign beat_o     = beat_q;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/tlp_tx_src.sv
module tlp_tx_src
  import tlp_tx_pkg::*;
#(
  parameter int MAX_DW  = 32,
  parameter int Q_DEPTH = 4,
  parameter int TAG_W   = 8,
  parameter int DROP_W  = 8,
  localparam int LEN_W  = $clog2(MAX_DW + 1),
  localparam int BEAT_W = $clog2(MAX_DW / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [1:0]        push_cls_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic [3:0]        buf_av_i,
  input  logic              abort_i,
  input  logic              dst_rdy_n_i,
  output logic [63:0]       td_o,
  output logic              sof_n_o,
  output logic              eof_n_o,
  output logic              src_rdy_n_o,
  output logic              src_dsc_n_o,
  output logic [7:0]        rem_n_o,
  output logic [1:0]        pl_cls_o,
  output logic [TAG_W-1:0]  pl_tag_o,
  output logic [BEAT_W-1:0] pl_beat_o,
  input  logic [63:0]       pl_data_i,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int DESC_W = TAG_W + LEN_W;

  logic [DESC_W-1:0] head_d [N_CLS];
  logic [DESC_W-1:0] head_sel;
  logic [N_CLS-1:0]  nonempty, elig;
  logic              pick_valid, launch, busy;
  logic [1:0]        pick_cls;

  for (genvar c = 0; c < N_CLS; c++) begin : g_q
    tlp_tx_desc_fifo #(.DEPTH(Q_DEPTH), .W(DESC_W)) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_i && (push_cls_i == 2'(c))),
      .data_i     ({push_tag_i, push_len_i}),
      .pop_i      (launch && (pick_cls == 2'(c))),
      .data_o     (head_d[c]),
      .nonempty_o (nonempty[c])
    );
    assign elig[c] = nonempty[c] && buf_av_i[c];
  end

  tlp_tx_pick u_pick (
    .elig_i     (elig),
    .cpl_safe_i (buf_av_i[3]),
    .valid_o    (pick_valid),
    .cls_o      (pick_cls)
  );

  always_comb begin
    case (pick_cls)
      CLS_P:   head_sel = head_d[CLS_P];
      CLS_CPL: head_sel = head_d[CLS_CPL];
      default: head_sel = head_d[CLS_NP];
    endcase
  end

  tlp_tx_framer #(
    .LEN_W (LEN_W), .BEAT_W(BEAT_W), .TAG_W(TAG_W), .DROP_W(DROP_W)
  ) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pick_valid_i (pick_valid),
    .pick_cls_i   (pick_cls),
    .head_len_i   (head_sel[LEN_W-1:0]),
    .head_tag_i   (head_sel[DESC_W-1:LEN_W]),
    .abort_i      (abort_i),
    .dst_rdy_n_i  (dst_rdy_n_i),
    .launch_o     (launch),
    .busy_o       (busy),
    .sof_n_o      (sof_n_o),
    .eof_n_o      (eof_n_o),
    .dsc_n_o      (src_dsc_n_o),
    .rem_n_o      (rem_n_o),
    .cls_o        (pl_cls_o),
    .tag_o        (pl_tag_o),
    .beat_o       (pl_beat_o),
    .drop_cnt_o   (drop_cnt_o)
  );

  assign src_rdy_n_o = !busy;
  assign td_o        = pl_data_i;
endmodule

// File: rtl/tlp_tx_src_chk.sv
module tlp_tx_src_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dst_rdy_n_i,
  input logic              src_rdy_n_o,
  input logic              sof_n_o,
  input logic              eof_n_o,
  input logic              src_dsc_n_o,
  input logic [7:0]        rem_n_o,
  input logic [63:0]       td_o,
  input logic [DROP_W-1:0] drop_cnt_o
);
  AST_FRAME_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_n_o || !eof_n_o) |-> !src_rdy_n_o); // R3

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_rdy_n_o && dst_rdy_n_i && src_dsc_n_o) |=>
      (!src_rdy_n_o && $stable(td_o) && $stable(sof_n_o) && $stable(eof_n_o) && $stable(rem_n_o))); // R2

  AST_REM_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_rdy_n_o && !eof_n_o) |-> (rem_n_o == 8'h00 || rem_n_o == 8'h0F)); // R4

  AST_REM_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_n_o |-> (rem_n_o == 8'h00)); // R4

  AST_DSC_AFTER_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_dsc_n_o |-> (!src_rdy_n_o && sof_n_o)); // R9

  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_dsc_n_o |=> (drop_cnt_o == $past(drop_cnt_o) + 1'b1)); // R9

  AST_DROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_dsc_n_o |=> $stable(drop_cnt_o)); // R9
endmodule

bind tlp_tx_src tlp_tx_src_chk #(.DROP_W(DROP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dst_rdy_n_i (dst_rdy_n_i),
  .src_rdy_n_o (src_rdy_n_o),
  .sof_n_o     (sof_n_o),
  .eof_n_o     (eof_n_o),
  .src_dsc_n_o (src_dsc_n_o),
  .rem_n_o     (rem_n_o),
  .td_o        (td_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/tlp_tx_src_tb.sv
module tlp_tx_src_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_DW  = 32;
  localparam int Q_DEPTH = 4;
  localparam int TAG_W   = 8;
  localparam int DROP_W  = 8;
  localparam int LEN_W   = $clog2(MAX_DW + 1);
  localparam int BEAT_W  = $clog2(MAX_DW / 2);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic push_i = 1'b0;
  logic [1:0] push_cls_i = '0;
  logic [LEN_W-1:0] push_len_i = '0;
  logic [TAG_W-1:0] push_tag_i = '0;
  logic [3:0] buf_av_i = '0;
  logic abort_i = 1'b0;
  logic dst_rdy_n_i = 1'b1;
  logic [63:0] td_o, pl_data_i;
  logic sof_n_o, eof_n_o, src_rdy_n_o, src_dsc_n_o;
  logic [7:0] rem_n_o;
  logic [1:0] pl_cls_o;
  logic [TAG_W-1:0] pl_tag_o;
  logic [BEAT_W-1:0] pl_beat_o;
  logic [DROP_W-1:0] drop_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] fpat(input logic [1:0] c, input logic [TAG_W-1:0] t,
                                       input logic [BEAT_W-1:0] b);
    return {t, c, 2'b01, 4'(b), 16'hA5C3 ^ {t, t}, 32'(b) * 32'h9E3779B1 ^ {24'h5A5A5A, t}};
  endfunction

  assign pl_data_i = fpat(pl_cls_o, pl_tag_o, pl_beat_o);

  tlp_tx_src #(.MAX_DW(MAX_DW), .Q_DEPTH(Q_DEPTH), .TAG_W(TAG_W), .DROP_W(DROP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_cls_i(push_cls_i),
    .push_len_i(push_len_i), .push_tag_i(push_tag_i), .buf_av_i(buf_av_i),
    .abort_i(abort_i), .dst_rdy_n_i(dst_rdy_n_i), .td_o(td_o), .sof_n_o(sof_n_o),
    .eof_n_o(eof_n_o), .src_rdy_n_o(src_rdy_n_o), .src_dsc_n_o(src_dsc_n_o),
    .rem_n_o(rem_n_o), .pl_cls_o(pl_cls_o), .pl_tag_o(pl_tag_o), .pl_beat_o(pl_beat_o),
    .pl_data_i(pl_data_i), .drop_cnt_o(drop_cnt_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model of the class queues
  int mq_len [3][64];
  int mq_tag [3][64];
  int mq_wr [3];
  int mq_rd [3];
  bit pend_v = 0;
  int pend_c, pend_l, pend_t;

  // expected framer state
  bit e_busy = 0, e_new = 0, e_chain = 0;
  int e_cls, e_len, e_tag, e_beat;
  logic [3:0] e_av_start;
  logic [DROP_W-1:0] e_drop = '0;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic int mcount(input int c);
    return mq_wr[c] - mq_rd[c];
  endfunction

  function automatic int choose(input logic [3:0] av);
    int order [3];
    if (av[3]) order = '{2, 1, 0};
    else       order = '{1, 0, 2};
    foreach (order[i])
      if (mcount(order[i]) > 0 && av[order[i]]) return order[i];
    return -1;
  endfunction

  task automatic step(input bit do_push, input int pc, input int pl, input int pt,
                      input logic [3:0] av, input bit dst_low, input bit ab);
    bit last, dsc, xfer, done;
    int c;
    @(negedge clk);
    if (pend_v) begin
      mq_len[pend_c][mq_wr[pend_c] % 64] = pend_l;
      mq_tag[pend_c][mq_wr[pend_c] % 64] = pend_t;
      mq_wr[pend_c]++;
      pend_v = 0;
    end
    check("R9 drop count", 64'(drop_cnt_o), 64'(e_drop));
    if (e_busy) begin
      last = (2 * e_beat + 2) >= e_len;
      check("R5 src_rdy active", 64'(src_rdy_n_o), 64'd0);
      if (e_new) begin
        check("R5 R6 class at launch", 64'(pl_cls_o), 64'(e_cls));
        check("R10 queue order tag", 64'(pl_tag_o), 64'(e_tag));
      end
      if (e_chain) check("R7 back-to-back sof", {62'd0, src_rdy_n_o, sof_n_o}, 64'd0);
      if (av != e_av_start) check("R8 packet continues", 64'(pl_tag_o), 64'(e_tag));
      check("R2 R11 beat index", 64'(pl_beat_o), 64'(e_beat));
      check("R3 sof", 64'(sof_n_o), 64'(e_beat != 0));
      check("R3 eof", 64'(eof_n_o), 64'(!last));
      check("R4 rem", 64'(rem_n_o), (last && (e_len % 2 == 1)) ? 64'h0F : 64'h00);
      check("R2 R11 data", td_o, fpat(2'(e_cls), TAG_W'(e_tag), BEAT_W'(e_beat)));
    end else begin
      check("R5 idle src_rdy", 64'(src_rdy_n_o), 64'd1);
      check("R3 idle sof", 64'(sof_n_o), 64'd1);
    end
    // drive this cycle's inputs
    push_i = do_push;
    push_cls_i = 2'(pc);
    push_len_i = LEN_W'(pl);
    push_tag_i = TAG_W'(pt);
    buf_av_i = av;
    dst_rdy_n_i = !dst_low;
    abort_i = ab;
    if (do_push && pc < 3 && mcount(pc) < Q_DEPTH) begin  // R10 full or class 3 ignored
      pend_v = 1; pend_c = pc; pend_l = pl; pend_t = pt;
    end
    #1;
    last = (2 * e_beat + 2) >= e_len;
    dsc  = e_busy && ab && (e_beat != 0);
    check("R9 discontinue", 64'(src_dsc_n_o), 64'(!dsc));
    xfer = e_busy && dst_low && !dsc;
    done = dsc || (xfer && last);
    if (dsc) e_drop = e_drop + 1'b1;
    if (xfer && !last) e_beat++;
    e_new = 0;
    e_chain = 0;
    if (!e_busy || done) begin
      c = choose(av);
      if (c >= 0) begin
        e_chain = e_busy;  // R7: launch in the same edge that ends a packet
        e_busy = 1; e_new = 1; e_cls = c; e_beat = 0; e_av_start = av;
        e_len = mq_len[c][mq_rd[c] % 64];
        e_tag = mq_tag[c][mq_rd[c] % 64];
        mq_rd[c]++;
      end else begin
        e_busy = 0;
      end
    end
  endtask

  task automatic idle(input int n, input logic [3:0] av, input bit dst_low);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, av, dst_low, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int seed_dummy;
    logic [3:0] av;
    seed_dummy = $urandom(32'h1234_5678);
    for (int c = 0; c < 3; c++) begin mq_wr[c] = 0; mq_rd[c] = 0; end
    // R1: reset values
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 reset src_rdy", 64'(src_rdy_n_o), 64'd1);
      check("R1 reset sof/eof", {62'd0, sof_n_o, eof_n_o}, 64'd3);
      check("R1 reset dsc", 64'(src_dsc_n_o), 64'd1);
      check("R1 reset drop", 64'(drop_cnt_o), 64'd0);
    end
    rst_ni = 1'b1;
    idle(2, 4'h0, 1);

    // R6 priority with completion look-ahead low: P, NP, CPL
    step(1, 0, 3, 8'h11, 4'h0, 1, 0);
    step(1, 1, 1, 8'h12, 4'h0, 1, 0);
    step(1, 2, 2, 8'h13, 4'h0, 1, 0);
    idle(3, 4'h0, 1);                     // R5: nothing eligible, stays idle
    idle(12, 4'b0111, 1);

    // R6 look-ahead high: CPL first
    step(1, 2, 4, 8'h21, 4'h0, 1, 0);
    step(1, 1, 2, 8'h22, 4'h0, 1, 0);
    step(1, 0, 5, 8'h23, 4'h0, 1, 0);
    idle(2, 4'h0, 1);
    idle(16, 4'hF, 1);

    // R10: five pushes into a depth-4 queue, class 3 push ignored
    for (int i = 0; i < 5; i++) step(1, 0, 2, 8'h30 + i, 4'h0, 1, 0);
    step(1, 3, 2, 8'h3F, 4'h0, 1, 0);
    idle(2, 4'h0, 1);
    idle(14, 4'b0001, 1);

    // R9: abort on first beat ignored, later honoured; abort while idle ignored
    step(0, 0, 1, 0, 4'h0, 0, 1);
    step(1, 1, 8, 8'h41, 4'h0, 0, 0);
    step(1, 1, 1, 8'h42, 4'h0, 0, 0);
    step(0, 0, 1, 0, 4'b0010, 0, 0);      // launch
    step(0, 0, 1, 0, 4'b0000, 1, 1);      // first beat with abort: ignored
    step(0, 0, 1, 0, 4'b0000, 0, 0);      // R2 stall
    step(0, 0, 1, 0, 4'b0000, 1, 0);
    step(0, 0, 1, 0, 4'b0010, 1, 1);      // discontinue, chain next
    idle(6, 4'b0010, 1);

    // random phase
    av = 4'hF;
    for (int i = 0; i < 4000; i++) begin
      bit dp, dl, ab;
      int pc, pl, pt;
      if ($urandom_range(0, 7) == 0) av = 4'($urandom_range(0, 15));
      dp = ($urandom_range(0, 2) == 0);
      pc = $urandom_range(0, 3);
      pl = $urandom_range(1, MAX_DW);
      pt = $urandom_range(0, 255);
      dl = ($urandom_range(0, 3) != 0);
      ab = ($urandom_range(0, 24) == 0);
      step(dp, pc, pl, pt, av, dl, ab);
    end
    idle(200, 4'hF, 1);
    finish_run();
  end
endmodule